// File: doc/BRIEF.md
# Soft-Start Current-Limit Sequencer

This block paces the start-up of a switching regulator. Once the regulator is enabled, it counts switching-cycle ticks and sends a small level code to an external current-limit DAC. The peak current limit starts at zero and rises in equal quarter steps until it reaches its full value. Each step lasts a fixed number of switching cycles, so the ramp follows the oscillator and not absolute time. With the defaults, the full ramp takes 512 cycles and each step takes 128.

A second, longer count arms undervoltage protection. This count gives the output time to come into regulation before an undervoltage trip is allowed. A shutdown, meaning the enable input is low, or a fault-restart request returns everything to the start point: both counts, the level code and both flags. Each new start then replays the ramp from zero.

Top module: `softstart_ilim_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `ilim_level` = 0, `ramp_done` = 0 and `uvp_arm` = 0.
- R2: After a clear, `ilim_level` stays at code 0 (0 % limit) until STEP_CYCLES ticks have been counted.
- R3: `ilim_level` encodes the limit as a count of quarters: 0=0 %, 1=25 %, 2=50 %, 3=75 %, 4=100 %. Codes 1, 2 and 3 appear on the clock edge that counts tick number STEP_CYCLES, 2·STEP_CYCLES and 3·STEP_CYCLES (128, 256 and 384 by default).
- R4: Code 4 and `ramp_done` = 1 both appear on the edge that counts tick number NUM_STEPS·STEP_CYCLES (512 by default). `ramp_done` is never 1 unless the code is 4.
- R5: A clock edge with `cycle_tick` = 0 changes none of the outputs.
- R6: `uvp_arm` rises on the edge that counts tick number UVP_CYCLES (5000 by default) and is 0 before that edge.
- R7: `run_en` = 0 at an edge clears the level code and both flags on that edge. They stay cleared for as long as `run_en` stays low.
- R8: `restart_req` = 1 at an edge clears the level code and both flags on that edge, even when a tick arrives in the same cycle.
- R9: Both counts saturate at their limits. Further ticks leave the code at 4 and keep both flags set, with no wrap.
- R10: While the block runs, the level code never falls, and it rises by at most one step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_tick | input | 1 | One-clock pulse per switching cycle |
| run_en | input | 1 | High to run the regulator; low means shutdown |
| restart_req | input | 1 | Fault-restart request; clears the sequence |
| ilim_level | output | $clog2(NUM_STEPS+1) (3) | Current-limit step code for the DAC |
| ramp_done | output | 1 | Full current limit has been reached |
| uvp_arm | output | 1 | Undervoltage protection is allowed to act |

## Verification
A clear request and a cycle tick can land on the same clock. This can also happen on the very tick that would move the code to its next step. The bench drives `restart_req` and `cycle_tick` together at such a boundary tick. It expects code 0 with both flags low one clock later. A second case pairs a tick with `run_en` dropping. The bench then re-runs the ramp from zero and checks that the first step boundary again falls at tick 128.

// File: rtl/softstart_ilim_pkg.sv
// Package: shared default sizing for the soft-start sequencer.
// It assumes the ramp limit and the protection delay each fit in 32 bits.
package softstart_ilim_pkg;

    localparam int DEF_STEP_CYCLES = 128;   // switching cycles per quarter step
    localparam int DEF_NUM_STEPS   = 4;     // quarter steps up to full limit
    localparam int DEF_UVP_CYCLES  = 5000;  // cycles before protection is armed

    // Bits needed to hold the values 0..n.
    function automatic int bits_for(input int n);
        int b;
        b = 1;
        while ((1 << b) <= n) b++;
        return b;
    endfunction

endpackage

// File: rtl/ssq_sat_counter.sv
// Saturating event counter with a sticky "limit reached" flag.
// It counts inc pulses from 0 up to LIMIT and then holds. The flag is set
// on the same edge that stores LIMIT. A clear wins over inc.
// It assumes LIMIT >= 1.
module ssq_sat_counter #(
    parameter int LIMIT = 512,
    localparam int CW   = softstart_ilim_pkg::bits_for(LIMIT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          full
);

    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt_q;
    logic          full_q;
    logic [CW-1:0] cnt_nx;

    // Next count value when a pulse is accepted.
    always_comb cnt_nx = cnt_q + CW'(1);

    // Count register: clear has priority, then saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (inc && !full_q) begin
            cnt_q <= cnt_nx;
        end
    end

    // Sticky flag: raised with the final increment, dropped only by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            full_q <= 1'b0;
        end else if (inc && !full_q && (cnt_nx == LIM_V)) begin
            full_q <= 1'b1;
        end
    end

    assign count = cnt_q;
    assign full  = full_q;

endmodule

// File: rtl/ssq_level_decode.sv
// Maps a ramp count to a step code.
// One comparator per step boundary gives a thermometer vector, and the code
// is the number of boundaries passed. It assumes the count never exceeds
// NUM_STEPS*STEP_CYCLES.
module ssq_level_decode #(
    parameter int STEP_CYCLES = 128,
    parameter int NUM_STEPS   = 4,
    localparam int CW = softstart_ilim_pkg::bits_for(STEP_CYCLES * NUM_STEPS),
    localparam int LW = softstart_ilim_pkg::bits_for(NUM_STEPS)
) (
    input  logic [CW-1:0] count,
    output logic [LW-1:0] level
);

    logic [NUM_STEPS-1:0] passed;

    // One threshold comparator per step boundary.
    for (genvar k = 0; k < NUM_STEPS; k++) begin : g_bound
        localparam logic [CW-1:0] EDGE_V = CW'((k + 1) * STEP_CYCLES);
        assign passed[k] = (count >= EDGE_V);
    end

    // Thermometer-to-binary: count the boundaries already crossed.
    always_comb begin
        level = '0;
        for (int k = 0; k < NUM_STEPS; k++) begin
            if (passed[k]) level = level + LW'(1);
        end
    end

endmodule

// File: rtl/softstart_ilim_seq.sv
// Soft-start current-limit sequencer (top).
// It counts switching-cycle ticks after enable and drives a stepped limit
// code plus two flags. A low run_en or a restart request clears all state.
// It assumes cycle_tick is a single-clock pulse that is synchronous to clk.
module softstart_ilim_seq #(
    parameter int STEP_CYCLES = softstart_ilim_pkg::DEF_STEP_CYCLES,
    parameter int NUM_STEPS   = softstart_ilim_pkg::DEF_NUM_STEPS,
    parameter int UVP_CYCLES  = softstart_ilim_pkg::DEF_UVP_CYCLES,
    localparam int RAMP_TOTAL = STEP_CYCLES * NUM_STEPS,
    localparam int RCW = softstart_ilim_pkg::bits_for(RAMP_TOTAL),
    localparam int UCW = softstart_ilim_pkg::bits_for(UVP_CYCLES),
    localparam int LW  = softstart_ilim_pkg::bits_for(NUM_STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cycle_tick,
    input  logic          run_en,
    input  logic          restart_req,
    output logic [LW-1:0] ilim_level,
    output logic          ramp_done,
    output logic          uvp_arm
);

    logic           seq_clear;
    logic [RCW-1:0] ramp_cnt;
    logic [UCW-1:0] uvp_cnt;
    logic           uvp_unused;

    // Any shutdown or restart request sends the sequence back to the start.
    always_comb seq_clear = !run_en || restart_req;

    // Ramp timer: saturates at the full-limit count.
    ssq_sat_counter #(.LIMIT(RAMP_TOTAL)) i_ramp_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (seq_clear),
        .inc   (cycle_tick),
        .count (ramp_cnt),
        .full  (ramp_done)
    );

    // Protection delay timer: counts the same ticks, with its own limit.
    ssq_sat_counter #(.LIMIT(UVP_CYCLES)) i_uvp_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (seq_clear),
        .inc   (cycle_tick),
        .count (uvp_cnt),
        .full  (uvp_arm)
    );

    // Only the flag of the protection timer is used; fold the count away.
    always_comb uvp_unused = ^uvp_cnt;

    // Step code derived from the ramp count.
    ssq_level_decode #(
        .STEP_CYCLES (STEP_CYCLES),
        .NUM_STEPS   (NUM_STEPS)
    ) i_level (
        .count (ramp_cnt),
        .level (ilim_level)
    );

endmodule

// File: rtl/softstart_ilim_seq_chk.sv
// Checker for the soft-start sequencer, attached to the top with bind.
// It watches only the ports and relates them across clock edges.
module softstart_ilim_seq_chk #(
    parameter int NUM_STEPS = 4,
    localparam int LW = softstart_ilim_pkg::bits_for(NUM_STEPS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cycle_tick,
    input logic          run_en,
    input logic          restart_req,
    input logic [LW-1:0] ilim_level,
    input logic          ramp_done,
    input logic          uvp_arm
);

    localparam logic [LW-1:0] TOP_CODE = LW'(NUM_STEPS);

    // R1: reset brings everything to the start point.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ilim_level == '0 && !ramp_done && !uvp_arm));

    // R7: shutdown clears the code and both flags.
    a_r7_shutdown_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (ilim_level == '0 && !ramp_done && !uvp_arm));

    // R8: a restart clears, whatever tick arrives with it.
    a_r8_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> (ilim_level == '0 && !ramp_done && !uvp_arm));

    // R5: no tick means no change.
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !restart_req && !cycle_tick)
        |=> ($stable(ilim_level) && $stable(ramp_done) && $stable(uvp_arm)));

    // R10: the code moves by zero or one step per clock while running.
    a_r10_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !restart_req)
        |=> (ilim_level == $past(ilim_level) || ilim_level == $past(ilim_level) + LW'(1)));

    // R4: the done flag only ever shows alongside the full-limit code.
    a_r4_done_full: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done |-> (ilim_level == TOP_CODE));

    // R9: once full and still running, the state stays saturated.
    a_r9_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_done && run_en && !restart_req)
        |=> (ramp_done && ilim_level == TOP_CODE));

    // R6: once armed and still running, protection stays armed.
    a_r6_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (uvp_arm && run_en && !restart_req) |=> uvp_arm);

endmodule

bind softstart_ilim_seq softstart_ilim_seq_chk #(.NUM_STEPS(NUM_STEPS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_tick  (cycle_tick),
    .run_en      (run_en),
    .restart_req (restart_req),
    .ilim_level  (ilim_level),
    .ramp_done   (ramp_done),
    .uvp_arm     (uvp_arm)
);

// File: tb/test_softstart_ilim_seq.sv
`timescale 1ns/1ps
module test_softstart_ilim_seq;

    localparam int STEP = 128;
    localparam int NST  = 4;
    localparam int UVP  = 5000;
    localparam int FULL = STEP * NST;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cycle_tick = 1'b0;
    logic       run_en = 1'b0;
    logic       restart_req = 1'b0;
    logic [2:0] ilim_level;
    logic       ramp_done;
    logic       uvp_arm;

    int n_checks = 0;
    int n_fails  = 0;
    int m_cnt = 0;   // bench model of ramp ticks
    int m_uv  = 0;   // bench model of protection ticks
    int prev_lvl = 0;

    always #2 clk = ~clk;   // 250 MHz

    softstart_ilim_seq #(
        .STEP_CYCLES (STEP),
        .NUM_STEPS   (NST),
        .UVP_CYCLES  (UVP)
    ) i_softstart_ilim_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_tick  (cycle_tick),
        .run_en      (run_en),
        .restart_req (restart_req),
        .ilim_level  (ilim_level),
        .ramp_done   (ramp_done),
        .uvp_arm     (uvp_arm)
    );

    // Expected code, computed arithmetically from the model count.
    function automatic int exp_level();
        int q;
        q = m_cnt / STEP;
        return (q > NST) ? NST : q;
    endfunction

    task automatic check_all(input string tag);
        int el;
        el = exp_level();
        n_checks++;
        if (int'(ilim_level) != el || ramp_done != (m_cnt >= FULL) || uvp_arm != (m_uv >= UVP)) begin
            n_fails++;
            $display("FAIL %s: level/done/arm actual %0d/%0b/%0b expected %0d/%0b/%0b",
                     tag, ilim_level, ramp_done, uvp_arm, el, (m_cnt >= FULL), (m_uv >= UVP));
        end
    endtask

    // One clock: drive at the falling edge, update the model, sample 1 ns after the rising edge.
    task automatic cycle(input logic t, input logic en, input logic rs);
        @(negedge clk);
        cycle_tick = t; run_en = en; restart_req = rs;
        @(posedge clk);
        if (!rst_n || !en || rs) begin
            m_cnt = 0; m_uv = 0;
        end else if (t) begin
            if (m_cnt < FULL) m_cnt++;
            if (m_uv < UVP) m_uv++;
        end
        #1;
    endtask

    task automatic tick_run(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            automatic logic t = !(gaps && (i % 7 == 3));
            string tag;
            cycle(t, 1'b1, 1'b0);
            if (!t) tag = "R5";
            else if (m_uv == UVP - 1 || m_uv == UVP) tag = "R6";
            else if (m_cnt < STEP) tag = "R2";
            else if (m_cnt < FULL) tag = "R3";
            else if (m_cnt == FULL && m_uv == FULL) tag = "R4";
            else tag = "R9";
            check_all(tag);
            n_checks++;   // R10: monotonic, single steps
            if (int'(ilim_level) < prev_lvl || int'(ilim_level) > prev_lvl + 1) begin
                n_fails++;
                $display("FAIL R10: level actual %0d expected %0d or %0d",
                         ilim_level, prev_lvl, prev_lvl + 1);
            end
            prev_lvl = int'(ilim_level);
        end
    endtask

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b0);
        check_all("R1");
        rst_n = 1'b1;

        // R2 R3 R4 R6 R9 R5 R10: full sweep with some idle cycles
        prev_lvl = 0;
        tick_run(UVP + 900, 1'b1);

        // R7: shutdown with a tick in the same cycle, held low for a while
        cycle(1'b1, 1'b0, 1'b0);
        check_all("R7");
        for (int i = 0; i < 5; i++) begin
            cycle(1'b1, 1'b0, 1'b0);
            check_all("R7");
        end

        // R2 R3: restart from zero after shutdown, first boundary at tick 128
        prev_lvl = 0;
        tick_run(STEP - 1, 1'b0);
        check_all("R2");
        tick_run(1, 1'b0);
        check_all("R3");
        tick_run(2 * STEP - 1, 1'b0);   // count 383: one tick before code 3

        // R8: restart together with the tick that would reach code 3
        cycle(1'b1, 1'b1, 1'b1);
        check_all("R8");
        prev_lvl = 0;
        tick_run(STEP, 1'b0);
        check_all("R8");

        // R1: reset in mid-ramp
        rst_n = 1'b0;
        cycle(1'b1, 1'b1, 1'b0);
        check_all("R1");
        rst_n = 1'b1;
        prev_lvl = 0;
        tick_run(10, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        n_fails++;
        $display("FAIL watchdog: run still active, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule